// File: doc/BRIEF.md
# I2C Rate Search Engine

This block works out the two divider fields that set an I2C controller's bus rate. It takes a source clock frequency and a wanted bus frequency, both in hertz. It then finds the sample count and step count whose product is the smallest divider that keeps the bus at or below the wanted rate. A one-cycle `start` latches the operands and launches the search. The block answers with a one-cycle `done`, and with either the two fields encoded as value minus one or the `no_fit` flag. A mode input, `code_phase`, runs the search at the fast-mode rate of 400 kHz whatever `bus_hz` holds. This serves the low-speed preamble that comes before a high-speed transfer.

All divisions use one restoring divider that produces one quotient bit per cycle. The first division gives the ideal divider, which is the ceiling of half the source clock over the effective target. The FSM then tries sample counts 1 through 8 in rising order, one divider run for each candidate. The FSM states are as follows:

- IDLE waits for `start`. From IDLE it goes to OPT on a nonzero effective target and to FINISH on a zero target.
- OPT waits for the ideal divider and then goes to STEP_GO.
- STEP_GO launches the candidate's division and goes to STEP.
- STEP judges the candidate. It returns to STEP_GO for the next sample count, or goes to VERIFY on an exact match or after sample count 8.
- VERIFY tests the chosen pair against the target and goes to FINISH.
- FINISH raises `done` for one cycle and returns to IDLE.

Top module: `i2c_rate_search`

## Requirements
- R1: During and directly after reset, `done`, `no_fit`, `sample_m1` and `step_m1` are all 0.
- R2: With `code_phase` low, a `bus_hz` above 3,400,000 is treated as exactly 3,400,000.
- R3: With `code_phase` high, the search uses 400,000 Hz as the target, whatever `bus_hz` holds.
- R4: The step count limit is 64 when the effective target is at most 400,000 Hz, and 8 when it is above that.
- R5: The ideal divider is ceil(floor(src_hz/2) / target), and a result of 0 is raised to 1. Sample counts 1 to 8 are tried in rising order, each with step = ceil(ideal / sample). A step above the limit is skipped. A candidate replaces the current best only when its product is strictly smaller, so on a tie the smaller sample count is kept. The best starts as 8 times the limit, with sample 8 and step equal to the limit.
- R6: The sweep stops at once when an accepted product equals the ideal divider. An exact match at sample count 1 completes within 128 cycles of `start`. A sweep over all eight candidates takes more than 256 cycles.
- R7: On success, `sample_m1` is the chosen sample count minus 1 and `step_m1` is the chosen step count minus 1.
- R8: `no_fit` is 1 when floor(src_hz / (2·sample·step)) exceeds the effective target. In that case `sample_m1` and `step_m1` are 0.
- R9: A zero effective target gives `no_fit` = 1 with both fields 0.
- R10: `done` is high for exactly one cycle per accepted `start`. The outputs keep their values until the next search completes.
- R11: A `start` that arrives while a search is in flight, including the cycle in which `done` is high, is ignored. It changes no result and causes no further `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request; operands are latched when it is accepted |
| src_hz | input | 32 | Source clock frequency in Hz |
| bus_hz | input | 32 | Wanted bus frequency in Hz |
| code_phase | input | 1 | High: search at the fixed 400 kHz preamble rate |
| done | output | 1 | One-cycle completion pulse |
| no_fit | output | 1 | No divider pair keeps the bus at or below the target |
| sample_m1 | output | 3 | Chosen sample count minus one |
| step_m1 | output | 6 | Chosen step count minus one |

## Verification
The `done` pulse and a fresh `start` can land in the same cycle. The FSM is then in FINISH and must drop the request on its way back to IDLE. The bench provokes this by raising `start` with new operands in the very cycle it sees `done`. It then watches for several hundred cycles: a correct design gives no second `done` and leaves the earlier result on the outputs. A second overlap, a request arriving halfway through a sweep, is judged the same way. The result must still reflect the first operands.

// File: rtl/rate_search_pkg.sv
`timescale 1ns/1ps
package rate_search_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPT,
        ST_STEP_GO,
        ST_STEP,
        ST_VERIFY,
        ST_FINISH
    } srch_state_t;

endpackage

// File: rtl/rate_div_restoring.sv
`timescale 1ns/1ps
module rate_div_restoring #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         done,
    output logic [W-1:0] quot,
    output logic [W-1:0] rem
);
    localparam int CW = $clog2(W + 1);
    localparam int DW = 2 * W;

    logic [W-1:0]  q_r;
    logic [W-1:0]  p_r;
    logic [W-1:0]  dvs_r;
    logic [W-1:0]  dnd_r;
    logic [CW-1:0] cnt_r;
    logic          run_r;
    logic [W:0]    shifted;
    logic          take;

    assign shifted = {p_r, q_r[W-1]};
    assign take    = shifted >= {1'b0, dvs_r};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_r   <= '0;
            p_r   <= '0;
            dvs_r <= '0;
            dnd_r <= '0;
            cnt_r <= '0;
            run_r <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go && !run_r) begin
                q_r   <= dividend;
                p_r   <= '0;
                dvs_r <= divisor;
                dnd_r <= dividend;
                cnt_r <= CW'(W);
                run_r <= 1'b1;
            end else if (run_r) begin
                q_r   <= {q_r[W-2:0], take};
                p_r   <= take ? W'(shifted - {1'b0, dvs_r}) : shifted[W-1:0];
                cnt_r <= cnt_r - CW'(1);
                if (cnt_r == CW'(1)) begin
                    run_r <= 1'b0;
                    done  <= 1'b1;
                end
            end
        end
    end

    assign quot = q_r;
    assign rem  = p_r;

    // R5: the divider result satisfies quotient*divisor + remainder = dividend
    assert_div_exact_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && dvs_r != '0) |->
            (DW'(quot) * DW'(dvs_r) + DW'(rem) == DW'(dnd_r)) && (rem < dvs_r));

endmodule

// File: rtl/rate_cand_eval.sv
`timescale 1ns/1ps
module rate_cand_eval #(
    parameter int W       = 32,
    parameter int CNT_W   = 4,
    parameter int CSTEP_W = 7,
    parameter int PROD_W  = 10
) (
    input  logic [W-1:0]       quot,
    input  logic [W-1:0]       rem,
    input  logic [CNT_W-1:0]   samp,
    input  logic [CSTEP_W-1:0] max_step,
    input  logic [PROD_W-1:0]  best_prod,
    output logic [CSTEP_W-1:0] step,
    output logic [PROD_W-1:0]  prod,
    output logic               fits,
    output logic               better
);
    logic [W:0] step_full;

    always_comb begin
        step_full = {1'b0, quot} + (W+1)'(rem != '0);
        fits      = step_full <= (W+1)'(max_step);
        step      = step_full[CSTEP_W-1:0];
        prod      = PROD_W'(step) * PROD_W'(samp);
        better    = fits && (prod < best_prod);
    end

endmodule

// File: rtl/i2c_rate_search.sv
`timescale 1ns/1ps
module i2c_rate_search
    import rate_search_pkg::*;
#(
    parameter int FREQ_W        = 32,
    parameter int SAMPLE_MAX    = 8,
    parameter int STEP_MAX_STD  = 64,
    parameter int STEP_MAX_HS   = 8,
    parameter int FAST_LIMIT_HZ = 400000,
    parameter int HS_LIMIT_HZ   = 3400000
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            start,
    input  logic [FREQ_W-1:0]               src_hz,
    input  logic [FREQ_W-1:0]               bus_hz,
    input  logic                            code_phase,
    output logic                            done,
    output logic                            no_fit,
    output logic [$clog2(SAMPLE_MAX)-1:0]   sample_m1,
    output logic [$clog2(STEP_MAX_STD)-1:0] step_m1
);
    localparam int SAMP_W  = $clog2(SAMPLE_MAX);
    localparam int STEP_W  = $clog2(STEP_MAX_STD);
    localparam int CNT_W   = $clog2(SAMPLE_MAX + 1);
    localparam int CSTEP_W = $clog2(STEP_MAX_STD + 1);
    localparam int PROD_W  = $clog2(SAMPLE_MAX * STEP_MAX_STD + 1);
    localparam int VW      = FREQ_W + PROD_W + 2;

    srch_state_t state_q, state_d;

    logic [FREQ_W-1:0]  src_q, teff_q, opt_q;
    logic               hs_q;
    logic [CNT_W-1:0]   s_cur, best_s;
    logic [CSTEP_W-1:0] best_t;
    logic [PROD_W-1:0]  best_prod;

    logic [FREQ_W-1:0]  teff_in;
    logic               hs_in;
    logic [CSTEP_W-1:0] max_step_in, max_step_q;
    logic               launch_ok, zero_req;

    logic               div_go, div_done;
    logic [FREQ_W-1:0]  div_dividend, div_divisor, div_q, div_r;
    logic [FREQ_W-1:0]  opt_ceil, opt_fix;

    logic [CSTEP_W-1:0] cand_step;
    logic [PROD_W-1:0]  cand_prod;
    logic               cand_fits, cand_better;
    logic               exact, last_samp;
    logic [VW-1:0]      verify_rhs;
    logic               too_fast;

    // effective target, limit selection and launch decode
    always_comb begin
        if (code_phase)
            teff_in = FREQ_W'(FAST_LIMIT_HZ);
        else if (bus_hz > FREQ_W'(HS_LIMIT_HZ))
            teff_in = FREQ_W'(HS_LIMIT_HZ);
        else
            teff_in = bus_hz;
        hs_in       = teff_in > FREQ_W'(FAST_LIMIT_HZ);
        max_step_in = hs_in ? CSTEP_W'(STEP_MAX_HS) : CSTEP_W'(STEP_MAX_STD);
        max_step_q  = hs_q  ? CSTEP_W'(STEP_MAX_HS) : CSTEP_W'(STEP_MAX_STD);
        launch_ok   = (state_q == ST_IDLE) && start && (teff_in != '0);
        zero_req    = (state_q == ST_IDLE) && start && (teff_in == '0);
    end

    // shared divider: ideal divider first, then one run per candidate
    always_comb begin
        div_go       = launch_ok || (state_q == ST_STEP_GO);
        div_dividend = (state_q == ST_IDLE) ? (src_hz >> 1) : opt_q;
        div_divisor  = (state_q == ST_IDLE) ? teff_in : FREQ_W'(s_cur);
        opt_ceil     = div_q + FREQ_W'(div_r != '0);
        opt_fix      = (opt_ceil == '0) ? FREQ_W'(1) : opt_ceil;
    end

    rate_div_restoring #(.W(FREQ_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (div_go),
        .dividend (div_dividend),
        .divisor  (div_divisor),
        .done     (div_done),
        .quot     (div_q),
        .rem      (div_r)
    );

    rate_cand_eval #(
        .W       (FREQ_W),
        .CNT_W   (CNT_W),
        .CSTEP_W (CSTEP_W),
        .PROD_W  (PROD_W)
    ) u_eval (
        .quot      (div_q),
        .rem       (div_r),
        .samp      (s_cur),
        .max_step  (max_step_q),
        .best_prod (best_prod),
        .step      (cand_step),
        .prod      (cand_prod),
        .fits      (cand_fits),
        .better    (cand_better)
    );

    always_comb begin
        exact      = cand_better && (FREQ_W'(cand_prod) == opt_q);
        last_samp  = (s_cur == CNT_W'(SAMPLE_MAX));
        verify_rhs = VW'(2) * VW'(best_s) * VW'(best_t) * (VW'(teff_q) + VW'(1));
        too_fast   = VW'(src_q) >= verify_rhs;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (launch_ok)     state_d = ST_OPT;
                else if (zero_req) state_d = ST_FINISH;
            end
            ST_OPT:     if (div_done) state_d = ST_STEP_GO;
            ST_STEP_GO: state_d = ST_STEP;
            ST_STEP: begin
                if (div_done)
                    state_d = (exact || last_samp) ? ST_VERIFY : ST_STEP_GO;
            end
            ST_VERIFY:  state_d = ST_FINISH;
            ST_FINISH:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // search datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q     <= '0;
            teff_q    <= '0;
            hs_q      <= 1'b0;
            opt_q     <= '0;
            s_cur     <= '0;
            best_s    <= '0;
            best_t    <= '0;
            best_prod <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (launch_ok) begin
                        src_q     <= src_hz;
                        teff_q    <= teff_in;
                        hs_q      <= hs_in;
                        best_prod <= PROD_W'(SAMPLE_MAX) * PROD_W'(max_step_in);
                        best_s    <= CNT_W'(SAMPLE_MAX);
                        best_t    <= max_step_in;
                    end
                end
                ST_OPT: begin
                    if (div_done) begin
                        opt_q <= opt_fix;
                        s_cur <= CNT_W'(1);
                    end
                end
                ST_STEP: begin
                    if (div_done) begin
                        if (cand_better) begin
                            best_prod <= cand_prod;
                            best_s    <= s_cur;
                            best_t    <= cand_step;
                        end
                        s_cur <= s_cur + CNT_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            no_fit    <= 1'b0;
            sample_m1 <= '0;
            step_m1   <= '0;
        end else if (zero_req) begin
            no_fit    <= 1'b1;
            sample_m1 <= '0;
            step_m1   <= '0;
        end else if (state_q == ST_VERIFY) begin
            if (too_fast) begin
                no_fit    <= 1'b1;
                sample_m1 <= '0;
                step_m1   <= '0;
            end else begin
                no_fit    <= 1'b0;
                sample_m1 <= SAMP_W'(best_s - CNT_W'(1));
                step_m1   <= STEP_W'(best_t - CSTEP_W'(1));
            end
        end
    end

    assign done = (state_q == ST_FINISH);

    // R10: completion is a single-cycle pulse
    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: a failed search leaves both fields at zero
    assert_fail_fields_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        no_fit |-> (sample_m1 == '0 && step_m1 == '0));

    // R5: candidates stay inside the sample range
    assert_samp_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STEP_GO || state_q == ST_STEP) |->
            (s_cur >= CNT_W'(1) && s_cur <= CNT_W'(SAMPLE_MAX)));

    // R5: the best product never grows while judging candidates
    assert_best_monotone_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STEP && div_done) |=> (best_prod <= $past(best_prod)));

    // R4: the chosen step never exceeds the limit for the latched target
    assert_step_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_VERIFY) |-> (best_t <= max_step_q && best_t != '0));

    // R2: the latched target never exceeds the high-speed ceiling
    assert_teff_clamp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> (teff_q <= FREQ_W'(HS_LIMIT_HZ)));

    // R11: operands cannot be reloaded while busy
    assert_busy_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> ($stable(src_q) && $stable(teff_q)));

endmodule

// File: tb/test_i2c_rate_search.sv
`timescale 1ns/1ps
module test_i2c_rate_search;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] src_hz = '0;
    logic [31:0] bus_hz = '0;
    logic        code_phase = 1'b0;
    logic        done;
    logic        no_fit;
    logic [2:0]  sample_m1;
    logic [5:0]  step_m1;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    i2c_rate_search i_i2c_rate_search (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .src_hz     (src_hz),
        .bus_hz     (bus_hz),
        .code_phase (code_phase),
        .done       (done),
        .no_fit     (no_fit),
        .sample_m1  (sample_m1),
        .step_m1    (step_m1)
    );

    // {src, target, mode, no_fit, sample-1, step-1}
    localparam int NV = 11;
    localparam logic [74:0] VEC [NV] = '{
        {32'd100000000, 32'd100000,   1'b0, 1'b0, 3'd7, 6'd62}, // R5 only s=8 fits
        {32'd16000000,  32'd400000,   1'b0, 1'b0, 3'd0, 6'd19}, // R4 limit 64 at 400 kHz
        {32'd16000000,  32'd400001,   1'b0, 1'b0, 3'd3, 6'd4},  // R4 limit 8 above it
        {32'd26000000,  32'd1000000,  1'b0, 1'b0, 3'd1, 6'd6},  // R5 tie keeps smaller sample
        {32'd100000000, 32'd10000000, 1'b0, 1'b0, 3'd2, 6'd4},  // R2 clamp
        {32'd100000000, 32'd3400000,  1'b1, 1'b0, 3'd4, 6'd24}, // R3 preamble rate
        {32'd100000000, 32'd1000000,  1'b0, 1'b0, 3'd6, 6'd7},  // R7 fields
        {32'd200000000, 32'd100000,   1'b0, 1'b1, 3'd0, 6'd0},  // R8 standard limit
        {32'd200000000, 32'd1000000,  1'b0, 1'b1, 3'd0, 6'd0},  // R8 high-speed limit
        {32'd1,         32'd100000,   1'b0, 1'b0, 3'd0, 6'd0},  // R5 ideal raised to 1
        {32'd5000,      32'd0,        1'b0, 1'b1, 3'd0, 6'd0}   // R9 zero target
    };

    function automatic string vreq(input int i);
        case (i)
            1, 2:    return "R4";
            4:       return "R2";
            5:       return "R3";
            6:       return "R7";
            7, 8:    return "R8";
            10:      return "R9";
            default: return "R5";
        endcase
    endfunction

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic launch(input logic [31:0] s, input logic [31:0] t, input logic m);
        @(negedge clk);
        src_hz = s;
        bus_hz = t;
        code_phase = m;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output int lat);
        lat = 1;
        while (!done && lat < 2000) begin
            @(negedge clk);
            lat++;
        end
        if (!done) chk("R10", "done never seen", 0, 1);
    endtask

    task automatic count_dones(input int cycles, output int seen);
        seen = 0;
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            if (done) seen++;
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int lat;
        int seen;
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1", "done in reset", done, 0);
        chk("R1", "no_fit in reset", no_fit, 0);
        chk("R1", "fields in reset", {sample_m1, step_m1}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "done after reset", done, 0);

        for (int i = 0; i < NV; i++) begin
            launch(VEC[i][74:43], VEC[i][42:11], VEC[i][10]);
            wait_done(lat);
            chk(vreq(i), $sformatf("vector %0d no_fit", i), no_fit, VEC[i][9]);
            chk(vreq(i), $sformatf("vector %0d sample_m1", i), sample_m1, VEC[i][8:6]);
            chk(vreq(i), $sformatf("vector %0d step_m1", i), step_m1, VEC[i][5:0]);
            if (i == 1) chk("R6", "early exit latency under 128", lat < 128, 1);
            if (i == 0) chk("R6", "full sweep latency over 256", lat > 256, 1);
            @(negedge clk);
            chk("R10", $sformatf("vector %0d done width", i), done, 0);
        end

        // R10: results hold after completion
        launch(VEC[3][74:43], VEC[3][42:11], VEC[3][10]);
        wait_done(lat);
        count_dones(30, seen);
        chk("R10", "no extra done while idle", seen, 0);
        chk("R10", "held fields", {no_fit, sample_m1, step_m1}, {1'b0, 3'd1, 6'd6});

        // R11: request in the middle of a sweep
        launch(VEC[0][74:43], VEC[0][42:11], VEC[0][10]);
        repeat (40) @(negedge clk);
        launch(VEC[1][74:43], VEC[1][42:11], VEC[1][10]);
        wait_done(lat);
        chk("R11", "mid-search start result", {no_fit, sample_m1, step_m1}, {1'b0, 3'd7, 6'd62});

        // R11: request in the same cycle as the done pulse
        src_hz = VEC[6][74:43];
        bus_hz = VEC[6][42:11];
        code_phase = VEC[6][10];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        count_dones(400, seen);
        chk("R11", "done-cycle start gives no done", seen, 0);
        chk("R11", "done-cycle start leaves result", {no_fit, sample_m1, step_m1}, {1'b0, 3'd7, 6'd62});

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule